// File: doc/BRIEF.md
# Two-Byte Measurement Read Snapshot Port

This block is the read side of a byte-addressed register space for a monitor whose measurements are 16-bit words. Each word occupies two neighbouring byte addresses, with the high byte at the lower address. Because the live measurements keep changing, reading the two halves at different times could give a pair that never existed. To prevent this, a read of the high byte of a measurement captures the whole word. Later reads of that word's low byte are answered from the capture until the surrounding read command ends.

A host sets `cmd_active` for the length of a read command. While it is set, the host strobes byte addresses. Each accepted strobe returns one byte on `rd_data` one clock later, marked by `rd_valid`. Each measurement has its own capture slot, so the host can interleave reads of different words inside one command and every word still reads back consistently. Temperature is an 11-bit two's-complement value with 0.125 °C per step. It is left-justified in its word. Every address that is not a measurement byte reads as zero.

Top module: `snap_read_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rd_valid` is 0 and `rd_data` is 00h.
- R2: A strobe taken while `cmd_active` is 1 gives `rd_valid`=1 with the new `rd_data` in the next cycle. A strobe taken while `cmd_active` is 0 gives no `rd_valid`, leaves `rd_data` unchanged and captures nothing.
- R3: A read of a high-byte address returns bits 15:8 of that word's live value in the strobe cycle. The same read captures all 16 bits of that value.
- R4: After a capture, reads of the same word's low byte return bits 7:0 of the captured value, even when the live value has changed.
- R5: A low-byte read that has no earlier capture of its word in the current command returns bits 7:0 of the live value.
- R6: Captures are kept per word. Capturing one word does not change what the low bytes of the other words return.
- R7: A repeated high-byte read inside the same command replaces that word's capture with the current live value.
- R8: When `cmd_active` is sampled at 0, all captures are dropped. The next command starts with no capture.
- R9: The temperature word is the 11-bit input shifted left by 5. The temperature low byte always has bits 4:0 equal to 0.
- R10: Every address other than the eight measurement bytes reads as 00h. This includes the reserved ranges 02h–06h, 09h–0Bh, 12h–17h and 1Ah–1Fh.
- R11: The address map is: voltage at 0Ch (high) and 0Dh (low), current at 0Eh/0Fh, accumulated current at 10h/11h, and temperature at 18h/19h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_active | input | 1 | High for the duration of a read command |
| rd_strobe | input | 1 | Read request for `rd_addr` |
| rd_addr | input | 8 | Byte address |
| volt_in | input | 16 | Live voltage word |
| curr_in | input | 16 | Live current word |
| acc_in | input | 16 | Live accumulated-current word |
| temp_in | input | 11 | Live temperature, two's complement, 0.125 °C per step |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |

## Verification
The assertions assume that the live words are sampled at the same clock edge as the strobe that reads them. They also assume that `cmd_active` is a clean level and does not toggle during reset. Beyond that, they place no ordering rule on the addresses the host reads. The stimulus changes the live inputs and the address only on the falling clock edge, between reads. It ends each command by holding `cmd_active` low for at least one rising edge. Addresses are drawn at random from the 00h–3Fh range, weighted toward the measurement bytes, so that every hold, fresh-read and re-capture ordering comes up.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int N_PAIRS = 4;
  localparam int IDX_W   = $clog2(N_PAIRS);

  typedef enum logic [IDX_W-1:0] {
    PAIR_VOLT = 2'd0,
    PAIR_CURR = 2'd1,
    PAIR_ACC  = 2'd2,
    PAIR_TEMP = 2'd3
  } pair_e;

  typedef struct packed {
    logic             hit;
    logic             low;
    logic [IDX_W-1:0] idx;
  } dec_t;

  localparam logic [ADDR_W-1:0] VOLT_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] CURR_HI = 8'h0E;
  localparam logic [ADDR_W-1:0] ACC_HI  = 8'h10;
  localparam logic [ADDR_W-1:0] TEMP_HI = 8'h18;

  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
    dec_t d;
    d.hit = 1'b1;
    d.low = a[0];
    d.idx = PAIR_VOLT;
    case ({a[ADDR_W-1:1], 1'b0})
      VOLT_HI: d.idx = PAIR_VOLT;
      CURR_HI: d.idx = PAIR_CURR;
      ACC_HI:  d.idx = PAIR_ACC;
      TEMP_HI: d.idx = PAIR_TEMP;
      default: begin
        d.hit = 1'b0;
        d.low = 1'b0;
      end
    endcase
    return d;
  endfunction

  function automatic logic [15:0] temp_to_word(input logic [10:0] t);
    return {t, 5'b00000};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [15:0] w, input logic low);
    return low ? w[7:0] : w[15:8];
  endfunction
endpackage

// File: rtl/snap_addr_decode.sv
module snap_addr_decode
  import snap_pkg::*;
#(
  parameter int NP = N_PAIRS
) (
  input  logic              cmd_active,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_fire,
  output dec_t              dec,
  output logic [NP-1:0]     cap_vec
);
  assign rd_fire = rd_strobe && cmd_active;
  assign dec     = decode_addr(rd_addr);

  for (genvar i = 0; i < NP; i++) begin : g_cap
    assign cap_vec[i] = rd_fire && dec.hit && !dec.low && (int'(dec.idx) == i);
  end
endmodule

// File: rtl/snap_slot.sv
module snap_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_active,
  input  logic         cap,
  input  logic [W-1:0] live,
  output logic [W-1:0] held,
  output logic         valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= '0;
      valid <= 1'b0;
    end else if (!cmd_active) begin
      valid <= 1'b0;
    end else if (cap) begin
      held  <= live;
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/snap_out_mux.sv
module snap_out_mux
  import snap_pkg::*;
#(
  parameter int NP = N_PAIRS,
  parameter int W  = 16
) (
  input  dec_t                  dec,
  input  logic [NP-1:0][W-1:0]  live_words,
  input  logic [NP-1:0][W-1:0]  held_words,
  input  logic [NP-1:0]         held_valid,
  output logic [BYTE_W-1:0]     next_byte
);
  logic [W-1:0] src_word;

  always_comb begin
    src_word = live_words[dec.idx];
    if (dec.low && held_valid[dec.idx]) src_word = held_words[dec.idx];
    next_byte = dec.hit ? pick_byte(src_word, dec.low) : '0;
  end
endmodule

// File: rtl/snap_read_port.sv
module snap_read_port
  import snap_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int TEMP_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_active,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] volt_in,
  input  logic [WORD_W-1:0] curr_in,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [TEMP_W-1:0] temp_in,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int NP = N_PAIRS;

  logic                     rd_fire;
  dec_t                     dec;
  logic [NP-1:0]            slot_cap;
  logic [NP-1:0]            slot_valid;
  logic [NP-1:0][WORD_W-1:0] slot_held;
  logic [NP-1:0][WORD_W-1:0] live_words;
  logic [BYTE_W-1:0]        next_byte;

  assign live_words[PAIR_VOLT] = volt_in;
  assign live_words[PAIR_CURR] = curr_in;
  assign live_words[PAIR_ACC]  = acc_in;
  assign live_words[PAIR_TEMP] = temp_to_word(temp_in);

  snap_addr_decode #(.NP(NP)) u_dec (
    .cmd_active (cmd_active),
    .rd_strobe  (rd_strobe),
    .rd_addr    (rd_addr),
    .rd_fire    (rd_fire),
    .dec        (dec),
    .cap_vec    (slot_cap)
  );

  for (genvar i = 0; i < NP; i++) begin : g_slot
    snap_slot #(.W(WORD_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_active (cmd_active),
      .cap        (slot_cap[i]),
      .live       (live_words[i]),
      .held       (slot_held[i]),
      .valid      (slot_valid[i])
    );
  end

  snap_out_mux #(.NP(NP), .W(WORD_W)) u_mux (
    .dec        (dec),
    .live_words (live_words),
    .held_words (slot_held),
    .held_valid (slot_valid),
    .next_byte  (next_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= next_byte;
    end
  end
endmodule

// File: rtl/snap_read_port_chk.sv
module snap_read_port_chk #(
  parameter int NP = 4,
  parameter int W  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_active,
  input logic                rd_strobe,
  input logic [7:0]          rd_addr,
  input logic [7:0]          rd_data,
  input logic                rd_valid,
  input logic [NP-1:0]       slot_cap,
  input logic [NP-1:0]       slot_valid,
  input logic [NP-1:0][W-1:0] slot_held,
  input logic [NP-1:0][W-1:0] live_words
);
  function automatic logic is_meas(input logic [7:0] a);
    return (a >= 8'h0C && a <= 8'h11) || a == 8'h18 || a == 8'h19;
  endfunction

  assert_valid_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_strobe && cmd_active));

  assert_inactive_no_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_active |-> slot_cap == '0);

  assert_single_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_cap));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_active |=> slot_valid == '0);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && cmd_active && !is_meas(rd_addr)) |=> rd_data == 8'h00);

  assert_temp_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && cmd_active && rd_addr == 8'h19) |=> rd_data[4:0] == 5'd0);

  for (genvar i = 0; i < NP; i++) begin : g_slot_chk
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_cap[i] |=> (slot_valid[i] && slot_held[i] == $past(live_words[i])));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid[i] && !slot_cap[i] && cmd_active) |=> ($stable(slot_held[i]) && slot_valid[i]));
  end
endmodule

bind snap_read_port snap_read_port_chk #(.NP(NP), .W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_active (cmd_active),
  .rd_strobe  (rd_strobe),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .slot_cap   (slot_cap),
  .slot_valid (slot_valid),
  .slot_held  (slot_held),
  .live_words (live_words)
);

// File: tb/snap_read_port_bench.sv
module snap_read_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_active = 1'b0;
  logic        rd_strobe = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] volt_in = '0, curr_in = '0, acc_in = '0;
  logic [10:0] temp_in = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_held [4];
  bit          m_val  [4];

  always #5 clk = ~clk;

  snap_read_port u_snap_read_port (
    .clk(clk), .rst_n(rst_n), .cmd_active(cmd_active), .rd_strobe(rd_strobe),
    .rd_addr(rd_addr), .volt_in(volt_in), .curr_in(curr_in), .acc_in(acc_in),
    .temp_in(temp_in), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // pair number for an address, or -1 when it is not a measurement byte
  function automatic int pair_of(input logic [7:0] a);
    if (a == 8'h0C || a == 8'h0D) return 0;
    if (a == 8'h0E || a == 8'h0F) return 1;
    if (a == 8'h10 || a == 8'h11) return 2;
    if (a == 8'h18 || a == 8'h19) return 3;
    return -1;
  endfunction

  function automatic logic [15:0] word_now(input int p);
    case (p)
      0: return volt_in;
      1: return curr_in;
      2: return acc_in;
      default: return temp_in * 16'd32;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 4; i++) m_val[i] = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag_in = "");
    int p;
    logic [7:0] exp;
    string tag;
    p = pair_of(a);
    if (p < 0) begin
      exp = 8'h00; tag = "R10";
    end else if (a[0] == 1'b0) begin
      m_held[p] = word_now(p); m_val[p] = 1;
      exp = m_held[p][15:8]; tag = "R3";
    end else if (m_val[p]) begin
      exp = m_held[p][7:0]; tag = (p == 3) ? "R9" : "R4";
    end else begin
      exp = word_now(p) & 16'h00FF; tag = (p == 3) ? "R9" : "R5";
    end
    if (tag_in != "") tag = tag_in;
    rd_addr = a; rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check({tag, " valid"}, {7'd0, rd_valid}, 8'h01);
    check(tag, rd_data, exp);
  endtask

  task automatic shake();
    volt_in = 16'($urandom); curr_in = 16'($urandom);
    acc_in  = 16'($urandom); temp_in = 11'($urandom);
  endtask

  task automatic end_cmd();
    cmd_active = 1'b0;
    @(negedge clk);
    clear_model();
    cmd_active = 1'b1;
  endtask

  function automatic logic [7:0] pick_addr();
    int r;
    logic [7:0] meas [8];
    meas = '{8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h10, 8'h11, 8'h18, 8'h19};
    r = $urandom_range(0, 9);
    if (r < 7) return meas[$urandom_range(0, 7)];
    return 8'($urandom_range(0, 63));
  endfunction

  initial begin
    logic [7:0] keep;
    void'($urandom(32'd7321));
    clear_model();
    repeat (3) @(negedge clk);
    check("R1 reset data", rd_data, 8'h00);
    check("R1 reset valid", {7'd0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {rd_valid, rd_data[6:0]}, 8'h00);

    // R2: strobe while inactive is dropped and captures nothing
    volt_in = 16'hA1B2;
    rd_addr = 8'h0C; rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check("R2 inactive valid", {7'd0, rd_valid}, 8'h00);
    check("R2 inactive data", rd_data, 8'h00);
    cmd_active = 1'b1;
    volt_in = 16'h1234;
    rd(8'h0D, "R2 no capture when inactive");

    // R11 map and R3/R4 hold
    volt_in = 16'h5A6B; curr_in = 16'h7C8D; acc_in = 16'h9EAF; temp_in = 11'h4C3;
    rd(8'h0C, "R11 volt hi");
    rd(8'h0E, "R11 curr hi");
    rd(8'h10, "R11 acc hi");
    rd(8'h18, "R11 temp hi");
    shake();
    rd(8'h0D, "R4 volt lo held");
    rd(8'h0F, "R4 curr lo held");
    rd(8'h11, "R4 acc lo held");
    rd(8'h19, "R9 temp lo held");
    end_cmd();

    // R6: capture of voltage leaves current live
    volt_in = 16'h1111; curr_in = 16'h2222;
    rd(8'h0C);
    curr_in = 16'h33C4; volt_in = 16'h4455;
    rd(8'h0F, "R6 other pair live");
    rd(8'h0D, "R6 captured pair held");
    // R7 recapture
    volt_in = 16'h6677;
    rd(8'h0C, "R7 recapture hi");
    volt_in = 16'h8899;
    rd(8'h0D, "R7 recapture lo");
    // R8 release
    end_cmd();
    rd(8'h0D, "R8 after release live");
    // R9 negative temperature
    temp_in = 11'h7FF;
    rd(8'h18, "R9 temp hi neg");
    temp_in = 11'h001;
    rd(8'h19, "R9 temp lo captured");
    end_cmd();
    // R10 reserved
    foreach (keep[i]) ;
    rd(8'h02, "R10 reserved 02"); rd(8'h0B, "R10 reserved 0B");
    rd(8'h12, "R10 reserved 12"); rd(8'h1F, "R10 reserved 1F");

    // random commands
    for (int c = 0; c < 300; c++) begin
      end_cmd();
      for (int k = 0; k < $urandom_range(1, 8); k++) begin
        if ($urandom_range(0, 1)) shake();
        rd(pick_addr());
      end
    end
    cmd_active = 1'b0;
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule